// File: doc/BRIEF.md
# Counting-Ramp Converter Controller

This block sequences a counting-type analog-to-digital conversion that is built from an external DAC and one comparator. When a start request arrives while the block is idle, it clears its code to zero and presents it to the DAC. It then raises the code by one per step, waiting a programmable number of clock cycles after every step so the DAC and comparator can settle, and only then looks at the comparator.

The comparator is low while the DAC output sits below the unknown input and goes high once the DAC output passes it. The first settled sample that reads high ends the conversion: the code that produced it is reported together with a one-cycle valid pulse. The code is built as a low byte that ramps from 0 to 255 and a two-bit upper segment that advances only when the low byte wraps, so the reported value is low + 256 × upper. If all 1024 codes pass without a crossing, an over-range pulse is raised instead and the reported code is the full-scale value.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy, valid and over-range are low, and the DAC code is 0.
- R2: A start request seen while idle sets busy high and the DAC code to 0 on the following cycle.
- R3: While busy, the DAC code changes only by +1, and consecutive changes are exactly SETTLE_CYC clock cycles apart.
- R4: The comparator passes through a two-flop synchronizer and is sampled once per step, at the end of the settling wait; the reported code is the code whose settled sample first reads 1 (for a comparator that goes high when the code exceeds a level T, the result is T+1; a comparator already high at code 0 gives 0).
- R5: The low eight code bits wrap from 255 to 0 while the upper two bits advance in the order 00, 01, 10, 11, so a crossing just after the first wrap reports 256 and one after the second wrap reports 512.
- R6: Valid is a one-cycle pulse carrying the result on result_o; busy falls in the same cycle, and valid and over-range are never high together.
- R7: If no settled sample reads 1 up to and including code 1023, over-range pulses for one cycle, valid stays low and result_o reads 1023.
- R8: A start request while busy is ignored: the code is not cleared and exactly one result is produced for the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| cmp_i | input | 1 | Asynchronous comparator output, 1 when the DAC output exceeds the input |
| dac_code_o | output | 10 | Code presented to the DAC |
| busy_o | output | 1 | High from an accepted start until the result or over-range pulse |
| valid_o | output | 1 | One-cycle pulse: result_o holds the crossing code |
| ovr_o | output | 1 | One-cycle pulse: no crossing, result_o holds full scale |
| result_o | output | 10 | Last reported code |

## Verification
The hardest outcomes to reach are those at the segment seams and at full scale: a crossing exactly at code 256 or 512 needs the lower byte to wrap and the upper bits to advance in the same step, and over-range only appears after every one of the 1024 steps has been walked. The bench models the comparator as a level threshold on the DAC code, so choosing the level 255, 511, 1022, 1023 or far above full scale forces each of these seams directly. A second start pulse injected in the middle of a long ramp, and a step monitor that times every code change, expose any restart or irregular settling.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RAMP = 1'b1
   } ramp_state_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmp_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);
   localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

   logic [CW-1:0] cnt_q;
   logic          run_q;

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("settle_timer needs CYC of at least one");
      end
   endgenerate

   assign expire_o = run_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= CW'(CYC - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   // R4: the count never leaves its loaded range
   p_timer_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(CYC - 1));
   // R4: a loaded wait runs without stopping until it expires
   p_timer_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> run_q);
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
   parameter int LO_W = 8,
   parameter int HI_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 inc_i,
   output logic [LO_W+HI_W-1:0] code_o,
   output logic                 top_o
);
   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;
   logic            lo_full;

   assign lo_full = (lo_q == {LO_W{1'b1}});
   assign code_o  = {hi_q, lo_q};
   assign top_o   = lo_full && (hi_q == {HI_W{1'b1}});

   // low byte ramps, restarting on every wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lo_q <= '0;
      else if (clr_i)  lo_q <= '0;
      else if (inc_i)  lo_q <= lo_q + 1'b1;
   end

   // upper segment advances only when the low byte wraps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_q <= '0;
      else if (clr_i)            hi_q <= '0;
      else if (inc_i && lo_full) hi_q <= hi_q + 1'b1;
   end

   // R5: a wrap of the low byte moves the upper segment up by exactly one
   p_seg_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && lo_full && !top_o) |=> (lo_q == '0) && (hi_q == $past(hi_q) + 1'b1));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
   import ramp_adc_pkg::*;
#(
   parameter int LO_W       = 8,
   parameter int HI_W       = 2,
   parameter int SETTLE_CYC = 4,
   parameter int SYNC_STG   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 cmp_i,
   output logic [LO_W+HI_W-1:0] dac_code_o,
   output logic                 busy_o,
   output logic                 valid_o,
   output logic                 ovr_o,
   output logic [LO_W+HI_W-1:0] result_o
);
   localparam int CODE_W = LO_W + HI_W;

   generate
      if (SETTLE_CYC < SYNC_STG + 1) begin : g_bad_settle
         $error("SETTLE_CYC must cover the synchronizer latency plus one");
      end
   endgenerate

   ramp_state_t       state_q;
   logic              cmp_s;
   logic              expire;
   logic              accept;
   logic              hit;
   logic              at_top;
   logic              step;
   logic              load;
   logic [CODE_W-1:0] code;

   cmp_sync #(.STAGES(SYNC_STG)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .sync_o(cmp_s));

   settle_timer #(.CYC(SETTLE_CYC)) timer_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .expire_o(expire));

   ramp_counter #(.LO_W(LO_W), .HI_W(HI_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .clr_i(accept), .inc_i(step),
      .code_o(code), .top_o(at_top));

   assign accept = (state_q == ST_IDLE) && start_i;
   assign hit    = (state_q == ST_RAMP) && expire && cmp_s;
   assign step   = (state_q == ST_RAMP) && expire && !cmp_s && !at_top;
   assign load   = accept || step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         valid_o  <= 1'b0;
         ovr_o    <= 1'b0;
         result_o <= '0;
      end else begin
         valid_o <= 1'b0;
         ovr_o   <= 1'b0;
         if (accept) begin
            state_q <= ST_RAMP;
         end else if (hit) begin
            state_q  <= ST_IDLE;
            valid_o  <= 1'b1;
            result_o <= code;
         end else if ((state_q == ST_RAMP) && expire && at_top) begin
            state_q  <= ST_IDLE;
            ovr_o    <= 1'b1;
            result_o <= {CODE_W{1'b1}};
         end
      end
   end

   assign dac_code_o = code;
   assign busy_o     = (state_q == ST_RAMP);

   // R2: an accepted start clears the code and raises busy
   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o && (dac_code_o == '0));
   // R3: during a conversion the code only ever moves up by one
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (dac_code_o != $past(dac_code_o)))
         |-> (dac_code_o == $past(dac_code_o) + 1'b1));
   // R6: valid and over-range exclusive
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && ovr_o));
   // R6: a reported result ends the conversion
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o || ovr_o) |-> !busy_o);
   // R7: over-range always reports full scale
   p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> (result_o == {CODE_W{1'b1}}));
   // R8: a start during a conversion does not clear the code
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && (dac_code_o != '0)) |=> (dac_code_o != '0));
endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb_top;
   localparam int SETTLE = 4;
   localparam int CW     = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cmp;
   logic [CW-1:0] dac;
   logic          busy, valid, ovr;
   logic [CW-1:0] result;
   int            thr = 5000;

   int total = 0;
   int bad = 0;
   int exp_code[$];
   bit exp_ovr[$];
   int n_results = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   always_comb cmp = (int'(dac) > thr);

   ramp_adc_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
      .dac_code_o(dac), .busy_o(busy), .valid_o(valid), .ovr_o(ovr),
      .result_o(result));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: one conversion against comparator level t
   task automatic convert(input int t, input bit poke_mid);
      while (busy) @(negedge clk);
      thr = t;
      if (t >= 1023) begin exp_code.push_back(1023); exp_ovr.push_back(1'b1); end
      else if (t < 0) begin exp_code.push_back(0); exp_ovr.push_back(1'b0); end
      else begin exp_code.push_back(t + 1); exp_ovr.push_back(1'b0); end
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy && dac == 0, "R2 busy and zero code after start", int'(dac), 0);
      if (poke_mid) begin
         repeat (SETTLE * 50) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
         @(negedge clk);
         // R8: start while busy ignored, ramp kept going
         check(busy && dac > 40, "R8 start ignored while busy", int'(dac), 50);
      end
      while (exp_code.size() != 0) @(negedge clk);
   endtask

   // step monitor for R3 / R5 spacing and increment
   int  since = 0;
   int  step_bad = 0;
   logic [CW-1:0] prev_dac = '0;
   bit  prev_busy = 1'b0;
   always @(negedge clk) begin
      if (busy) begin
         if (!prev_busy) since = 0;
         else begin
            since++;
            if (dac != prev_dac) begin
               if (int'(dac) != int'(prev_dac) + 1 || since != SETTLE) step_bad++;
               since = 0;
            end
         end
      end
      prev_dac  = dac;
      prev_busy = busy;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (valid || ovr)) begin
         n_results++;
         if (exp_code.size() == 0) begin
            check(1'b0, "R8 unexpected extra result", int'(result), -1);
         end else begin
            int  ec;
            bit  eo;
            ec = exp_code.pop_front();
            eo = exp_ovr.pop_front();
            check(result == ec, eo ? "R7 over-range code" : "R4 result code", int'(result), ec);
            check(ovr == eo && valid == !eo, "R7 flag kind", int'({valid, ovr}), eo ? 1 : 2);
            check(!busy, "R6 busy falls with result", int'(busy), 0);
            check(step_bad == 0, "R3 step spacing and increment", step_bad, 0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !valid && !ovr && dac == 0, "R1 reset state",
            int'({busy, valid, ovr}) + int'(dac), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !valid && !ovr && dac == 0, "R1 idle after reset",
            int'({busy, valid, ovr}) + int'(dac), 0);
      convert(-1, 1'b0);    // R4 already high at code 0
      convert(0, 1'b0);     // R4 -> 1
      convert(100, 1'b0);   // R4 -> 101
      convert(254, 1'b0);   // R5 -> 255, last of first segment
      convert(255, 1'b0);   // R5 -> 256, first wrap
      convert(511, 1'b0);   // R5 -> 512, second wrap
      convert(700, 1'b1);   // R8 mid-conversion start
      convert(1022, 1'b0);  // R4 -> 1023
      convert(1023, 1'b0);  // R7 no crossing
      convert(4000, 1'b0);  // R7 far above full scale
      repeat (10) @(negedge clk);
      // R6 valid is a single-cycle pulse; R8 no extra results appeared
      check(!valid && !ovr, "R6 pulses ended", int'({valid, ovr}), 0);
      check(n_results == 10, "R8 one result per accepted start", n_results, 10);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule